// File: doc/BRIEF.md
# Timer Compare Waveform Generator

This block is an 8-bit timer with one compare register and one waveform pin. A two-bit counting-mode field selects one of four behaviours: a free-running count, a count that restarts after matching the compare value, a single-slope PWM, or a dual-slope (up/down) PWM. A separate two-bit output-action field then decides what a compare match, or reaching the top of the count, does to the waveform register. When the output is disconnected, the pin carries an ordinary port data bit.

The counter only steps on clock cycles where the enable tick is high. Software-style write strobes load the counting mode, the output action and the compare value. In the two PWM modes, a new compare value is staged and only takes effect at the top of the count, so a period never sees a half-updated threshold. A registered match flag reports every enabled step on which the count equals the active compare value.

Top module: `cmpwave_timer`

## Requirements
- R1: After the asynchronous active-low reset, the counter, compare value, waveform register, counting mode and output action are all 0. The pin therefore follows `port_data` and `match_pulse` is 0.
- R2: The counter changes only on a clock edge where `tick` is 1. With `tick` at 0, no match is flagged and the waveform does not change.
- R3: Counting mode 0 (free-running) steps 0,1,…,255 and then wraps to 0. `match_pulse` is 1 for exactly the cycle after an enabled edge on which the count equalled the active compare value. This holds in every mode.
- R4: Counting mode 1 (restart on match) steps up by one per tick. On the tick where the count equals the compare value, the next count is 0.
- R5: In counting modes 0 and 1, output action 1 toggles the waveform on a match, action 2 drives it to 0, and action 3 drives it to 1.
- R6: Output action 0 disconnects the waveform in every counting mode, so the pin equals `port_data`. In counting modes 2 and 3, action 1 also disconnects it.
- R7: Counting mode 2 (single-slope PWM) counts 0 to 255 and wraps. With action 2, a match drives the waveform to 0 and the tick at count 255 drives it to 1. Action 3 does the opposite.
- R8: Counting mode 3 (dual-slope PWM) counts up to 255, then down to 0, reversing at each end. With action 2, a match while counting up drives the waveform to 0 and a match while counting down drives it to 1. Action 3 does the opposite.
- R9: In modes 2 and 3 with action 2 or 3, when the active compare value is 255 the match has no effect on the waveform, although `match_pulse` still fires. At the count-255 tick, the waveform is driven to 1 for action 2 and to 0 for action 3.
- R10: In modes 2 and 3, a written compare value is staged and becomes active on the enabled edge at count 255. In modes 0 and 1, it becomes active on the edge of the write. Which rule applies is decided by the mode in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for this cycle |
| mode_we | input | 1 | Load strobe for the counting mode |
| mode_wdata | input | 2 | Counting mode: 0 free, 1 restart, 2 single-slope PWM, 3 dual-slope PWM |
| com_we | input | 1 | Load strobe for the output action |
| com_wdata | input | 2 | Output action code |
| cmp_we | input | 1 | Load strobe for the compare value |
| cmp_wdata | input | 8 | Compare value |
| port_data | input | 1 | Pin value while the waveform is disconnected |
| wave_out | output | 1 | Pin output |
| match_pulse | output | 1 | Registered compare-match flag |

## Verification
Four properties are checked on every cycle:
- the count stays frozen while `tick` is low;
- the restart mode returns to zero after a match;
- in PWM modes the active compare value changes only at the top event;
- when the compare value is 255, the top action wins.

Only the bench scenarios can show the whole waveform shape. This covers the toggle, clear and set sequences, the inverted and non-inverted PWM duty, the direction-dependent actions of the dual-slope mode, and the port-data bypass. A behavioural reference model, compared on every clock, covers these.

// File: rtl/cmpwave_pkg.sv
package cmpwave_pkg;
  typedef enum logic [1:0] {
    WM_FREE  = 2'd0,
    WM_CTC   = 2'd1,
    WM_FAST  = 2'd2,
    WM_PHASE = 2'd3
  } wave_mode_e;

  function automatic logic is_pwm(wave_mode_e m);
    return (m == WM_FAST) || (m == WM_PHASE);
  endfunction
endpackage

// File: rtl/cmpwave_counter.sv
module cmpwave_counter
  import cmpwave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wave_mode_e   mode,
  input  logic [W-1:0] cmp_act,
  output logic [W-1:0] cnt,
  output logic         cnt_up,
  output logic         top_evt
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (tick) begin
      unique case (mode)
        WM_FREE, WM_FAST: cnt_d = cnt_q + CNT_ONE;
        WM_CTC:           cnt_d = (cnt_q == cmp_act) ? '0 : cnt_q + CNT_ONE;
        WM_PHASE: begin
          if (up_q) begin
            if (cnt_q == CNT_MAX) begin
              up_d  = 1'b0;
              cnt_d = CNT_MAX - CNT_ONE;
            end else begin
              cnt_d = cnt_q + CNT_ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              up_d  = 1'b1;
              cnt_d = CNT_ONE;
            end else begin
              cnt_d = cnt_q - CNT_ONE;
            end
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt     = cnt_q;
  assign cnt_up  = up_q;
  assign top_evt = tick && is_pwm(mode) && (cnt_q == CNT_MAX);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  assert_ctc_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == WM_CTC && cnt_q == cmp_act) |=> (cnt_q == '0));
endmodule

// File: rtl/cmpwave_cmpreg.sv
module cmpwave_cmpreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm,
  input  logic         top_evt,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmp_act
);
  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] act_q, act_d;

  always_comb begin
    stage_d = we ? wdata : stage_q;
    act_d   = act_q;
    if (we && !pwm) act_d = wdata;
    else if (top_evt) act_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  assign cmp_act = act_q;

  assert_stage_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !top_evt) |=> $stable(act_q));
endmodule

// File: rtl/cmpwave_outgen.sv
module cmpwave_outgen
  import cmpwave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wave_mode_e   mode,
  input  logic [1:0]   com,
  input  logic [W-1:0] cnt,
  input  logic         cnt_up,
  input  logic         top_evt,
  input  logic [W-1:0] cmp_act,
  input  logic         port_data,
  output logic         wave_out,
  output logic         match_pulse
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic oc_q, oc_d;
  logic mt_q, mt_d;
  logic hit, disc;

  always_comb begin
    hit  = tick && (cnt == cmp_act);
    mt_d = hit;
    oc_d = oc_q;
    unique case (mode)
      WM_FREE, WM_CTC: begin
        if (hit) begin
          unique case (com)
            2'b01:   oc_d = ~oc_q;
            2'b10:   oc_d = 1'b0;
            2'b11:   oc_d = 1'b1;
            default: oc_d = oc_q;
          endcase
        end
      end
      WM_FAST: begin
        if (com[1]) begin
          if (top_evt)  oc_d = ~com[0];
          else if (hit) oc_d = com[0];
        end
      end
      WM_PHASE: begin
        if (com[1]) begin
          if (top_evt && cmp_act == CNT_MAX) oc_d = ~com[0];
          else if (hit) oc_d = cnt_up ? com[0] : ~com[0];
        end
      end
      default: oc_d = oc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q <= 1'b0;
      mt_q <= 1'b0;
    end else begin
      oc_q <= oc_d;
      mt_q <= mt_d;
    end
  end

  assign disc        = (com == 2'b00) || (is_pwm(mode) && com == 2'b01);
  assign wave_out    = disc ? port_data : oc_q;
  assign match_pulse = mt_q;

  assert_top_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (top_evt && com[1] && cmp_act == CNT_MAX) |=> (oc_q == !$past(com[0])));
endmodule

// File: rtl/cmpwave_timer.sv
module cmpwave_timer
  import cmpwave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         mode_we,
  input  logic [1:0]   mode_wdata,
  input  logic         com_we,
  input  logic [1:0]   com_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         port_data,
  output logic         wave_out,
  output logic         match_pulse
);
  wave_mode_e   mode_q, mode_d;
  logic [1:0]   com_q, com_d;
  logic [W-1:0] cnt, cmp_act;
  logic         cnt_up, top_evt;

  always_comb begin
    mode_d = mode_we ? wave_mode_e'(mode_wdata) : mode_q;
    com_d  = com_we ? com_wdata : com_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WM_FREE;
      com_q  <= 2'b00;
    end else begin
      mode_q <= mode_d;
      com_q  <= com_d;
    end
  end

  cmpwave_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .cmp_act(cmp_act),
    .cnt(cnt), .cnt_up(cnt_up), .top_evt(top_evt)
  );

  cmpwave_cmpreg #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pwm(is_pwm(mode_q)), .top_evt(top_evt),
    .we(cmp_we), .wdata(cmp_wdata), .cmp_act(cmp_act)
  );

  cmpwave_outgen #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .com(com_q),
    .cnt(cnt), .cnt_up(cnt_up), .top_evt(top_evt), .cmp_act(cmp_act),
    .port_data(port_data), .wave_out(wave_out), .match_pulse(match_pulse)
  );
endmodule

// File: tb/cmpwave_timer_tb.sv
module cmpwave_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic mode_we = 1'b0, com_we = 1'b0, cmp_we = 1'b0;
  logic [1:0] mode_wdata = 2'd0, com_wdata = 2'd0;
  logic [7:0] cmp_wdata = 8'd0;
  logic port_data = 1'b0;
  logic wave_out, match_pulse;

  int errs = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0, m_up = 1, m_buf = 0, m_act = 0, m_oc = 0, m_match = 0;
  int m_mode = 0, m_com = 0;

  always #4 clk = ~clk;

  cmpwave_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .com_we(com_we), .com_wdata(com_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .port_data(port_data), .wave_out(wave_out), .match_pulse(match_pulse)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int pwm, hit, top, c0, c1, exp_wave;
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_buf = 0; m_act = 0; m_oc = 0; m_match = 0;
      m_mode = 0; m_com = 0;
    end else begin
      pwm = (m_mode >= 2);
      hit = (tick && m_cnt == m_act);
      top = (tick && pwm && m_cnt == 255);
      c0 = m_com % 2;
      c1 = m_com / 2;
      if (m_mode < 2) begin
        if (hit) begin
          if (m_com == 1) m_oc = 1 - m_oc;
          else if (m_com == 2) m_oc = 0;
          else if (m_com == 3) m_oc = 1;
        end
      end else if (c1 == 1) begin
        if (m_mode == 2) begin
          if (top) m_oc = 1 - c0;
          else if (hit) m_oc = c0;
        end else begin
          if (top && m_act == 255) m_oc = 1 - c0;
          else if (hit) m_oc = m_up ? c0 : 1 - c0;
        end
      end
      if (tick) begin
        case (m_mode)
          1: m_cnt = (m_cnt == m_act) ? 0 : (m_cnt + 1) % 256;
          3: begin
            if (m_up == 1) begin
              if (m_cnt == 255) begin m_up = 0; m_cnt = 254; end
              else m_cnt = m_cnt + 1;
            end else begin
              if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
              else m_cnt = m_cnt - 1;
            end
          end
          default: m_cnt = (m_cnt + 1) % 256;
        endcase
      end
      if (cmp_we && !pwm) m_act = cmp_wdata;
      else if (top) m_act = m_buf;
      if (cmp_we) m_buf = cmp_wdata;
      m_match = hit;
      if (mode_we) m_mode = mode_wdata;
      if (com_we) m_com = com_wdata;
    end
    #2;
    if (!done) begin
      exp_wave = (m_com == 0 || (m_mode >= 2 && m_com == 1)) ? port_data : m_oc;
      check(cur_req, "wave_out", wave_out, exp_wave);
      check(cur_req, "match_pulse", match_pulse, m_match);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(int md, int cm, int cv);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = md[1:0];
    com_we = 1'b1; com_wdata = cm[1:0];
    cmp_we = 1'b1; cmp_wdata = cv[7:0];
    @(negedge clk);
    mode_we = 1'b0; com_we = 1'b0; cmp_we = 1'b0;
  endtask

  task automatic set_cmp(int cv);
    @(negedge clk);
    cmp_we = 1'b1; cmp_wdata = cv[7:0];
    @(negedge clk);
    cmp_we = 1'b0;
  endtask

  task automatic run(int n, int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (i % every == 0);
      port_data = (i % 7 < 3);
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R1: reset state, pin follows port data
    cur_req = "R1";
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    port_data = 1'b1; #1;
    check("R1", "wave_out bypass high", wave_out, 1);
    check("R1", "match_pulse at reset", match_pulse, 0);
    port_data = 1'b0; #1;
    check("R1", "wave_out bypass low", wave_out, 0);

    cur_req = "R3/R5 free toggle";
    do_reset(); cfg(0, 1, 5); run(600, 1);
    cur_req = "R2 gated tick";
    do_reset(); cfg(0, 3, 7); run(900, 3);
    cur_req = "R5 set then clear";
    do_reset(); cfg(0, 3, 20); run(300, 1); cfg(0, 2, 40); run(300, 1);
    cur_req = "R4 restart";
    do_reset(); cfg(1, 1, 10); run(300, 1);
    cur_req = "R4 restart at zero";
    do_reset(); cfg(1, 1, 0); run(40, 1);
    cur_req = "R6 disconnected";
    do_reset(); cfg(0, 0, 3); run(300, 1); cfg(2, 1, 50); run(600, 1);
    cfg(3, 1, 50); run(600, 1);
    cur_req = "R7 fast non-inverting";
    do_reset(); cfg(2, 2, 100); run(700, 1);
    cur_req = "R7 fast inverting";
    do_reset(); cfg(2, 3, 100); run(700, 1);
    cur_req = "R8 dual-slope 2";
    do_reset(); cfg(3, 2, 100); run(1200, 1);
    cur_req = "R8 dual-slope 3";
    do_reset(); cfg(3, 3, 30); run(1200, 2);
    cur_req = "R9 fast cmp top";
    do_reset(); cfg(2, 2, 255); run(800, 1);
    cur_req = "R9 dual cmp top";
    do_reset(); cfg(3, 3, 255); run(1200, 1);
    cur_req = "R10 staged fast";
    do_reset(); cfg(2, 2, 60); run(400, 1); set_cmp(200); run(150, 1); run(500, 1);
    cur_req = "R10 staged dual";
    do_reset(); cfg(3, 2, 60); run(300, 1); set_cmp(180); run(1200, 1);
    cur_req = "R10 immediate free";
    do_reset(); cfg(0, 1, 60); run(100, 1); set_cmp(90); run(400, 1);

    done = 1'b1;
    #3;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule